// File: doc/BRIEF.md
# Prioritized Window and Shadow Generator

This block sits in the pixel path of an on-screen display engine. For every pixel it takes the current character-cell row and column, the pixel offset inside the cell and the scan line inside the row. It compares these against four programmable rectangular background windows. It reports whether the pixel lies in a window body or in a window's drop shadow. It also returns the colour and intensity that the pixel should take.

Each window has inclusive start and end bounds, counted in character cells. When shadowing is enabled, a band is drawn just past the right edge of the window, and a second band is drawn just below its bottom edge. The band sizes are given by small codes. Overlaps resolve by a fixed ranking, so the lowest-numbered window always wins. The result is registered, so it appears one pixel clock after the position is presented.

Top module: `osdWindowMixer`

## Requirements
- R1: A window whose enable bit is 1 covers every pixel whose cell row is within its start and end rows and whose cell column is within its start and end columns, bounds included. There, winHit is 1, shadowHit is 0 and rgbOut is the window colour. The colour code is {R,G,B}: 000 black, 001 blue, 010 green, 011 cyan, 100 red, 101 magenta, 110 yellow, 111 white.
- R2: Window index 0 has the highest rank and index 3 the lowest. Where window bodies overlap, rgbOut carries the colour of the lowest-indexed covering window.
- R3: A window whose start row exceeds its end row, or whose start column exceeds its end column, produces neither body nor shadow, even while it is enabled.
- R4: A window whose enable bit is 0 produces neither body nor shadow.
- R5: With shadow enabled, a pixel is a right-shadow pixel when its cell column equals end column + 1 and its pixel offset is below M. Here M = 2, 4, 6 or 8 for width code 0, 1, 2 or 3. Its row must lie within the window rows or within the bottom band. There, shadowHit is 1, winHit is 0 and rgbOut is the window's shadow colour.
- R6: With shadow enabled, a pixel is a bottom-shadow pixel when its cell row equals end row + 1 and its scan line is below N. Here N = 2, 4, 6 or 8 for height code 0, 1, 2 or 3. Its column must lie within the window columns or within the right band. The band does not wrap past the last row.
- R7: The winner is the lowest-indexed window that has either a body or a shadow at the pixel. A higher-ranked body therefore hides a lower-ranked shadow, and a higher-ranked shadow hides a lower-ranked body. winHit and shadowHit are never both 1.
- R8: On a body or shadow pixel, intensityOut is the OR of the winning window's intensity bit and rowIntensity. On any other pixel, intensityOut equals rowIntensity.
- R9: A pixel covered by no body and no shadow gives winHit 0, shadowHit 0 and rgbOut 000.
- R10: While rstN is low, all outputs are 0.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge, so back-to-back pixels give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellRow | input | 4 | Character-cell row of the current pixel |
| cellCol | input | 5 | Character-cell column of the current pixel |
| pixInCell | input | 4 | Pixel offset inside the cell |
| lineInRow | input | 6 | Scan line inside the character row |
| rowIntensity | input | 1 | Intensity bit of the current text row |
| winEnable | input | 4 | Per-window enable, bit i for window i |
| winIntensity | input | 4 | Per-window intensity, 1 = high |
| winShadowEn | input | 4 | Per-window shadow enable |
| winRowStart | input | 16 | Start rows, window i at bits [4i+3:4i] |
| winRowEnd | input | 16 | End rows, window i at bits [4i+3:4i] |
| winColStart | input | 20 | Start columns, window i at bits [5i+4:5i] |
| winColEnd | input | 20 | End columns, window i at bits [5i+4:5i] |
| winColour | input | 12 | Body colours, window i at bits [3i+2:3i] |
| winShadowColour | input | 12 | Shadow colours, window i at bits [3i+2:3i] |
| winShadowW | input | 8 | Shadow width codes, window i at bits [2i+1:2i] |
| winShadowH | input | 8 | Shadow height codes, window i at bits [2i+1:2i] |
| winHit | output | 1 | Registered: pixel is in the winning window body |
| rgbOut | output | 3 | Registered colour {R,G,B} |
| intensityOut | output | 1 | Registered intensity, 1 = high |
| shadowHit | output | 1 | Registered: pixel is in the winning window shadow |

## Verification
Single windows are probed at their inclusive corners and one cell outside them. This separates off-by-one bound errors from plain comparison errors. Shadow bands are probed at the last pixel or line inside the band and the first one outside it, for several size codes. This tells a wrong code-to-size mapping apart from a wrong band origin. Overlapping pairs pit a body against a body, a body against a shadow, and a shadow against a body, which exposes a reversed or incomplete ranking. Inverted and disabled windows are placed over otherwise hit pixels, and the outputs must stay quiet. A back-to-back hit and miss pair confirms the one-cycle alignment.

// File: rtl/osdWinPkg.sv
package osdWinPkg;
  localparam int WIN_COUNT = 4;
  localparam int RGB_W     = 3;
  localparam int CODE_W    = 2;

  typedef enum logic [RGB_W-1:0] {
    RGB_BLACK   = 3'b000,
    RGB_BLUE    = 3'b001,
    RGB_GREEN   = 3'b010,
    RGB_CYAN    = 3'b011,
    RGB_RED     = 3'b100,
    RGB_MAGENTA = 3'b101,
    RGB_YELLOW  = 3'b110,
    RGB_WHITE   = 3'b111
  } rgbCode_e;

  // Strobes passed from hit detection (control) to colour selection (datapath)
  typedef struct packed {
    logic [WIN_COUNT-1:0] body;
    logic [WIN_COUNT-1:0] shade;
  } winStrobes_t;

  // Band size in pixels or lines for a 2-bit code: 2, 4, 6, 8
  function automatic logic [3:0] spanOfCode(input logic [CODE_W-1:0] code);
    return {1'b0, code, 1'b0} + 4'd2;
  endfunction
endpackage

// File: rtl/winRectCheck.sv
module winRectCheck
  import osdWinPkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int PIX_W  = 4,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  cellRow,
  input  logic [COL_W-1:0]  cellCol,
  input  logic [PIX_W-1:0]  pixInCell,
  input  logic [LINE_W-1:0] lineInRow,
  input  logic              enable,
  input  logic              shadowEn,
  input  logic [ROW_W-1:0]  rowStart,
  input  logic [ROW_W-1:0]  rowEnd,
  input  logic [COL_W-1:0]  colStart,
  input  logic [COL_W-1:0]  colEnd,
  input  logic [CODE_W-1:0] shadowWCode,
  input  logic [CODE_W-1:0] shadowHCode,
  output logic              bodyHit,
  output logic              shadeHit
);
  logic             validRect;
  logic             rowIn, colIn;
  logic [ROW_W:0]   rowAfter;
  logic [COL_W:0]   colAfter;
  logic [PIX_W-1:0] pixLimit;
  logic [LINE_W-1:0] lineLimit;
  logic             rowBand, colBand;
  logic             rowExt, colExt;

  always_comb begin
    validRect = enable && (rowStart <= rowEnd) && (colStart <= colEnd);
    rowIn     = (cellRow >= rowStart) && (cellRow <= rowEnd);
    colIn     = (cellCol >= colStart) && (cellCol <= colEnd);
    // one extra bit so the band past the last row/column never wraps to 0
    rowAfter  = {1'b0, rowEnd} + (ROW_W+1)'(1);
    colAfter  = {1'b0, colEnd} + (COL_W+1)'(1);
    pixLimit  = PIX_W'(spanOfCode(shadowWCode));
    lineLimit = LINE_W'(spanOfCode(shadowHCode));
    rowBand   = ({1'b0, cellRow} == rowAfter) && (lineInRow < lineLimit);
    colBand   = ({1'b0, cellCol} == colAfter) && (pixInCell < pixLimit);
    rowExt    = rowIn || rowBand;
    colExt    = colIn || colBand;
    bodyHit   = validRect && rowIn && colIn;
    shadeHit  = validRect && shadowEn && rowExt && colExt && !(rowIn && colIn);
  end

  AST_INVERTED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((rowStart > rowEnd) || (colStart > colEnd)) |-> (!bodyHit && !shadeHit)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!bodyHit && !shadeHit)); // R4
  AST_SHADE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    shadeHit |-> shadowEn); // R5
  AST_BODY_SHADE_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    !(bodyHit && shadeHit)); // R7
endmodule

// File: rtl/winHitCtrl.sv
module winHitCtrl
  import osdWinPkg::*;
#(
  parameter int NUM_WIN = WIN_COUNT,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 5,
  parameter int PIX_W   = 4,
  parameter int LINE_W  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ROW_W-1:0]          cellRow,
  input  logic [COL_W-1:0]          cellCol,
  input  logic [PIX_W-1:0]          pixInCell,
  input  logic [LINE_W-1:0]         lineInRow,
  input  logic [NUM_WIN-1:0]        winEnable,
  input  logic [NUM_WIN-1:0]        winShadowEn,
  input  logic [NUM_WIN*ROW_W-1:0]  winRowStart,
  input  logic [NUM_WIN*ROW_W-1:0]  winRowEnd,
  input  logic [NUM_WIN*COL_W-1:0]  winColStart,
  input  logic [NUM_WIN*COL_W-1:0]  winColEnd,
  input  logic [NUM_WIN*CODE_W-1:0] winShadowW,
  input  logic [NUM_WIN*CODE_W-1:0] winShadowH,
  output winStrobes_t               strobes
);
  logic [NUM_WIN-1:0] bodyVec, shadeVec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    winRectCheck #(
      .ROW_W(ROW_W), .COL_W(COL_W), .PIX_W(PIX_W), .LINE_W(LINE_W)
    ) uRect (
      .clk        (clk),
      .rstN       (rstN),
      .cellRow    (cellRow),
      .cellCol    (cellCol),
      .pixInCell  (pixInCell),
      .lineInRow  (lineInRow),
      .enable     (winEnable[w]),
      .shadowEn   (winShadowEn[w]),
      .rowStart   (winRowStart[w*ROW_W +: ROW_W]),
      .rowEnd     (winRowEnd[w*ROW_W +: ROW_W]),
      .colStart   (winColStart[w*COL_W +: COL_W]),
      .colEnd     (winColEnd[w*COL_W +: COL_W]),
      .shadowWCode(winShadowW[w*CODE_W +: CODE_W]),
      .shadowHCode(winShadowH[w*CODE_W +: CODE_W]),
      .bodyHit    (bodyVec[w]),
      .shadeHit   (shadeVec[w])
    );
  end

  always_comb begin
    strobes.body  = bodyVec;
    strobes.shade = shadeVec;
  end
endmodule

// File: rtl/winColourPath.sv
module winColourPath
  import osdWinPkg::*;
#(
  parameter int NUM_WIN = WIN_COUNT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  winStrobes_t              strobes,
  input  logic                     rowIntensity,
  input  logic [NUM_WIN-1:0]       winIntensity,
  input  logic [NUM_WIN*RGB_W-1:0] winColour,
  input  logic [NUM_WIN*RGB_W-1:0] winShadowColour,
  output logic                     winHit,
  output logic [RGB_W-1:0]         rgbOut,
  output logic                     intensityOut,
  output logic                     shadowHit
);
  logic             selBody, selShade, selInt;
  logic [RGB_W-1:0] selRgb;

  // Scan from lowest rank upward so the lowest index is assigned last and wins
  always_comb begin
    selBody  = 1'b0;
    selShade = 1'b0;
    selRgb   = RGB_BLACK;
    selInt   = rowIntensity;
    for (int i = NUM_WIN-1; i >= 0; i--) begin
      if (strobes.body[i]) begin
        selBody  = 1'b1;
        selShade = 1'b0;
        selRgb   = winColour[i*RGB_W +: RGB_W];
        selInt   = rowIntensity | winIntensity[i];
      end else if (strobes.shade[i]) begin
        selBody  = 1'b0;
        selShade = 1'b1;
        selRgb   = winShadowColour[i*RGB_W +: RGB_W];
        selInt   = rowIntensity | winIntensity[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winHit       <= 1'b0;
      shadowHit    <= 1'b0;
      rgbOut       <= RGB_BLACK;
      intensityOut <= 1'b0;
    end else begin
      winHit       <= selBody;
      shadowHit    <= selShade;
      rgbOut       <= selRgb;
      intensityOut <= selInt;
    end
  end

  AST_TOP_RANK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.body[0] |=> (winHit && rgbOut == $past(winColour[RGB_W-1:0]))); // R2
  AST_QUIET_IS_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    (!winHit && !shadowHit) |-> (rgbOut == RGB_BLACK)); // R9
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(winHit && shadowHit)); // R7
  AST_MISS_ROW_INTENSITY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.body == '0 && strobes.shade == '0) |=>
      (!winHit && !shadowHit && intensityOut == $past(rowIntensity))); // R8
  AST_SHADE_ONLY_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.body == '0 && strobes.shade != '0) |=> shadowHit); // R11
endmodule

// File: rtl/osdWindowMixer.sv
module osdWindowMixer
  import osdWinPkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int PIX_W  = 4,
  parameter int LINE_W = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ROW_W-1:0]            cellRow,
  input  logic [COL_W-1:0]            cellCol,
  input  logic [PIX_W-1:0]            pixInCell,
  input  logic [LINE_W-1:0]           lineInRow,
  input  logic                        rowIntensity,
  input  logic [WIN_COUNT-1:0]        winEnable,
  input  logic [WIN_COUNT-1:0]        winIntensity,
  input  logic [WIN_COUNT-1:0]        winShadowEn,
  input  logic [WIN_COUNT*ROW_W-1:0]  winRowStart,
  input  logic [WIN_COUNT*ROW_W-1:0]  winRowEnd,
  input  logic [WIN_COUNT*COL_W-1:0]  winColStart,
  input  logic [WIN_COUNT*COL_W-1:0]  winColEnd,
  input  logic [WIN_COUNT*RGB_W-1:0]  winColour,
  input  logic [WIN_COUNT*RGB_W-1:0]  winShadowColour,
  input  logic [WIN_COUNT*CODE_W-1:0] winShadowW,
  input  logic [WIN_COUNT*CODE_W-1:0] winShadowH,
  output logic                        winHit,
  output logic [RGB_W-1:0]            rgbOut,
  output logic                        intensityOut,
  output logic                        shadowHit
);
  localparam int NUM_WIN = WIN_COUNT;

  winStrobes_t strobes;

  winHitCtrl #(
    .NUM_WIN(NUM_WIN), .ROW_W(ROW_W), .COL_W(COL_W), .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cellRow    (cellRow),
    .cellCol    (cellCol),
    .pixInCell  (pixInCell),
    .lineInRow  (lineInRow),
    .winEnable  (winEnable),
    .winShadowEn(winShadowEn),
    .winRowStart(winRowStart),
    .winRowEnd  (winRowEnd),
    .winColStart(winColStart),
    .winColEnd  (winColEnd),
    .winShadowW (winShadowW),
    .winShadowH (winShadowH),
    .strobes    (strobes)
  );

  winColourPath #(.NUM_WIN(NUM_WIN)) uPath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .rowIntensity   (rowIntensity),
    .winIntensity   (winIntensity),
    .winColour      (winColour),
    .winShadowColour(winShadowColour),
    .winHit         (winHit),
    .rgbOut         (rgbOut),
    .intensityOut   (intensityOut),
    .shadowHit      (shadowHit)
  );
endmodule

// File: tb/osdWindowMixer_bench.sv
module osdWindowMixer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cellRow = '0;
  logic [4:0]  cellCol = '0;
  logic [3:0]  pixInCell = '0;
  logic [5:0]  lineInRow = '0;
  logic        rowIntensity = 1'b0;
  logic [3:0]  winEnable = '0, winIntensity = '0, winShadowEn = '0;
  logic [15:0] winRowStart = '0, winRowEnd = '0;
  logic [19:0] winColStart = '0, winColEnd = '0;
  logic [11:0] winColour = '0, winShadowColour = '0;
  logic [7:0]  winShadowW = '0, winShadowH = '0;
  logic        winHit, intensityOut, shadowHit;
  logic [2:0]  rgbOut;

  int vecCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  osdWindowMixer u_osdWindowMixer (
    .clk(clk), .rstN(rstN), .cellRow(cellRow), .cellCol(cellCol),
    .pixInCell(pixInCell), .lineInRow(lineInRow), .rowIntensity(rowIntensity),
    .winEnable(winEnable), .winIntensity(winIntensity), .winShadowEn(winShadowEn),
    .winRowStart(winRowStart), .winRowEnd(winRowEnd),
    .winColStart(winColStart), .winColEnd(winColEnd),
    .winColour(winColour), .winShadowColour(winShadowColour),
    .winShadowW(winShadowW), .winShadowH(winShadowH),
    .winHit(winHit), .rgbOut(rgbOut), .intensityOut(intensityOut), .shadowHit(shadowHit)
  );

  task automatic clearWins();
    winEnable = '0; winIntensity = '0; winShadowEn = '0;
    winRowStart = '0; winRowEnd = '0; winColStart = '0; winColEnd = '0;
    winColour = '0; winShadowColour = '0; winShadowW = '0; winShadowH = '0;
  endtask

  task automatic setWin(input int idx, input logic [3:0] rs, input logic [3:0] re,
                        input logic [4:0] cs, input logic [4:0] ce, input logic [2:0] col,
                        input logic inten);
    winEnable[idx] = 1'b1;
    winIntensity[idx] = inten;
    winRowStart[idx*4 +: 4] = rs;
    winRowEnd[idx*4 +: 4] = re;
    winColStart[idx*5 +: 5] = cs;
    winColEnd[idx*5 +: 5] = ce;
    winColour[idx*3 +: 3] = col;
  endtask

  task automatic setShadow(input int idx, input logic [2:0] col,
                           input logic [1:0] wCode, input logic [1:0] hCode);
    winShadowEn[idx] = 1'b1;
    winShadowColour[idx*3 +: 3] = col;
    winShadowW[idx*2 +: 2] = wCode;
    winShadowH[idx*2 +: 2] = hCode;
  endtask

  task automatic drive(input logic [3:0] r, input logic [4:0] c, input logic [3:0] p,
                       input logic [5:0] l, input logic ri);
    cellRow = r; cellCol = c; pixInCell = p; lineInRow = l; rowIntensity = ri;
  endtask

  task automatic compare(input logic eHit, input logic eShd, input logic [2:0] eRgb,
                         input logic eInt, input string tag);
    vecCount++;
    if (winHit !== eHit || shadowHit !== eShd || rgbOut !== eRgb || intensityOut !== eInt) begin
      failCount++;
      $display("FAIL %s: got hit=%b shd=%b rgb=%b int=%b, expected hit=%b shd=%b rgb=%b int=%b",
               tag, winHit, shadowHit, rgbOut, intensityOut, eHit, eShd, eRgb, eInt);
    end
  endtask

  // drive after a falling edge, one rising edge registers, sample at next falling edge
  task automatic probe(input logic [3:0] r, input logic [4:0] c, input logic [3:0] p,
                       input logic [5:0] l, input logic ri,
                       input logic eHit, input logic eShd, input logic [2:0] eRgb,
                       input logic eInt, input string tag);
    @(negedge clk);
    drive(r, c, p, l, ri);
    @(negedge clk);
    compare(eHit, eShd, eRgb, eInt, tag);
  endtask

  task automatic testReset();
    drive(4'd3, 5'd7, 4'd0, 6'd0, 1'b1);
    setWin(0, 4'd0, 4'd15, 5'd0, 5'd31, 3'b111, 1'b1);
    @(negedge clk);
    compare(1'b0, 1'b0, 3'b000, 1'b0, "R10 outputs low in reset");
    clearWins();
  endtask

  task automatic testBody();
    clearWins();
    setWin(1, 4'd2, 4'd4, 5'd5, 5'd10, 3'b100, 1'b0);
    probe(4'd3, 5'd7, 4'd3, 6'd1, 1'b0, 1'b1, 1'b0, 3'b100, 1'b0, "R1 interior hit");
    probe(4'd2, 5'd5, 4'd0, 6'd0, 1'b0, 1'b1, 1'b0, 3'b100, 1'b0, "R1 top-left corner");
    probe(4'd4, 5'd10, 4'd11, 6'd9, 1'b1, 1'b1, 1'b0, 3'b100, 1'b1, "R1 bottom-right corner, R8 row high");
    probe(4'd1, 5'd7, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R9 row above window");
    probe(4'd3, 5'd11, 4'd0, 6'd0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, "R9 column right, no shadow; R8 row bit passes");
    probe(4'd3, 5'd4, 4'd11, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R9 column left of window");
  endtask

  task automatic testPriority();
    clearWins();
    setWin(0, 4'd0, 4'd3, 5'd0, 5'd5, 3'b001, 1'b0);
    setWin(2, 4'd2, 4'd6, 5'd3, 5'd9, 3'b010, 1'b1);
    probe(4'd2, 5'd4, 4'd0, 6'd0, 1'b0, 1'b1, 1'b0, 3'b001, 1'b0, "R2 overlap picks window 0");
    probe(4'd5, 5'd8, 4'd0, 6'd0, 1'b0, 1'b1, 1'b0, 3'b010, 1'b1, "R8 high window forces high");
    setWin(3, 4'd2, 4'd6, 5'd3, 5'd9, 3'b110, 1'b0);
    probe(4'd5, 5'd8, 4'd0, 6'd0, 1'b0, 1'b1, 1'b0, 3'b010, 1'b1, "R2 window 2 over window 3");
  endtask

  task automatic testInverted();
    clearWins();
    setWin(3, 4'd8, 4'd6, 5'd2, 5'd9, 3'b111, 1'b1);
    setShadow(3, 3'b101, 2'd3, 2'd3);
    probe(4'd7, 5'd5, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R3 rows inverted, inside span");
    probe(4'd7, 5'd10, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R3 rows inverted, no right shadow");
    clearWins();
    setWin(2, 4'd1, 4'd5, 5'd9, 5'd3, 3'b111, 1'b1);
    probe(4'd3, 5'd5, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R3 columns inverted");
  endtask

  task automatic testDisabled();
    clearWins();
    setWin(1, 4'd0, 4'd10, 5'd0, 5'd20, 3'b011, 1'b1);
    setShadow(1, 3'b110, 2'd3, 2'd3);
    winEnable[1] = 1'b0;
    probe(4'd5, 5'd5, 4'd2, 6'd2, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R4 disabled body quiet");
    probe(4'd11, 5'd5, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R4 disabled shadow quiet");
  endtask

  task automatic testRightShadow();
    clearWins();
    setWin(0, 4'd2, 4'd4, 5'd5, 5'd10, 3'b100, 1'b1);
    setShadow(0, 3'b111, 2'd1, 2'd0);
    probe(4'd3, 5'd11, 4'd3, 6'd0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, "R5 code1 last pixel in band");
    probe(4'd3, 5'd11, 4'd4, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R5 code1 first pixel past band");
    winShadowW[1:0] = 2'd3;
    probe(4'd2, 5'd11, 4'd7, 6'd0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, "R5 code3 pixel 7");
    probe(4'd2, 5'd11, 4'd8, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R5 code3 pixel 8");
    winShadowW[1:0] = 2'd0;
    probe(4'd4, 5'd11, 4'd1, 6'd0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, "R5 code0 pixel 1");
    probe(4'd4, 5'd11, 4'd2, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R5 code0 pixel 2");
    probe(4'd3, 5'd12, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R5 two columns right is clear");
  endtask

  task automatic testBottomShadow();
    clearWins();
    setWin(0, 4'd2, 4'd4, 5'd5, 5'd10, 3'b100, 1'b0);
    setShadow(0, 3'b011, 2'd0, 2'd2);
    probe(4'd5, 5'd7, 4'd0, 6'd5, 1'b0, 1'b0, 1'b1, 3'b011, 1'b0, "R6 code2 line 5");
    probe(4'd5, 5'd7, 4'd0, 6'd6, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R6 code2 line 6");
    probe(4'd5, 5'd11, 4'd1, 6'd0, 1'b0, 1'b0, 1'b1, 3'b011, 1'b0, "R6 corner of both bands");
    probe(4'd5, 5'd4, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R6 left of start column");
    probe(4'd6, 5'd7, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R6 two rows below is clear");
    winShadowH[1:0] = 2'd3;
    probe(4'd5, 5'd10, 4'd0, 6'd7, 1'b0, 1'b0, 1'b1, 3'b011, 1'b0, "R6 code3 line 7");
    probe(4'd5, 5'd10, 4'd0, 6'd8, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R6 code3 line 8");
    clearWins();
    setWin(0, 4'd10, 4'd15, 5'd0, 5'd3, 3'b010, 1'b0);
    setShadow(0, 3'b110, 2'd0, 2'd3);
    probe(4'd0, 5'd1, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, "R6 last row band does not wrap");
  endtask

  task automatic testOverride();
    clearWins();
    setWin(0, 4'd0, 4'd0, 5'd2, 5'd3, 3'b011, 1'b0);
    setWin(1, 4'd0, 4'd1, 5'd0, 5'd1, 3'b101, 1'b1);
    setShadow(1, 3'b110, 2'd1, 2'd0);
    setWin(2, 4'd1, 4'd1, 5'd2, 5'd2, 3'b010, 1'b0);
    probe(4'd0, 5'd2, 4'd1, 6'd0, 1'b0, 1'b1, 1'b0, 3'b011, 1'b0, "R7 higher body hides lower shadow");
    probe(4'd1, 5'd2, 4'd1, 6'd0, 1'b0, 1'b0, 1'b1, 3'b110, 1'b1, "R7 higher shadow hides lower body");
    probe(4'd1, 5'd2, 4'd5, 6'd0, 1'b0, 1'b1, 1'b0, 3'b010, 1'b0, "R7 lower body past shadow band");
  endtask

  task automatic testLatency();
    clearWins();
    setWin(2, 4'd4, 4'd4, 5'd4, 5'd4, 3'b101, 1'b0);
    @(negedge clk);
    drive(4'd4, 5'd4, 4'd0, 6'd0, 1'b0);
    @(negedge clk);
    compare(1'b1, 1'b0, 3'b101, 1'b0, "R11 hit one cycle after input");
    drive(4'd4, 5'd5, 4'd0, 6'd0, 1'b1);
    @(negedge clk);
    compare(1'b0, 1'b0, 3'b000, 1'b1, "R11 miss on the very next cycle");
    drive(4'd4, 5'd4, 4'd0, 6'd0, 1'b0);
    @(negedge clk);
    compare(1'b1, 1'b0, 3'b101, 1'b0, "R11 hit again back to back");
  endtask

  initial begin
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testBody();
    testPriority();
    testInverted();
    testDisabled();
    testRightShadow();
    testBottomShadow();
    testOverride();
    testLatency();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule